// File: doc/BRIEF.md
# 1-Wire Bus Master Controller

This block lets a host drive a 1-Wire network one byte at a time. The host sees five byte-wide registers on a simple synchronous bus: command, data, status, interrupt enable and clock divisor. Writes take effect at the clock edge. Read data is combinational from the address. A read strobe applies read side effects, such as clear-on-read, at the same edge. On the wire side the block drives an open-drain enable, where 1 pulls the line low, and samples the line through a two-stage synchroniser.

All wire timing is counted in ticks of a time base that fires once every divisor+1 clocks. In normal operation the divisor is chosen so that one tick is 1 us. A bus reset holds the line low, releases it, and samples for a presence pulse. Writing the data register queues a byte. The byte is shifted out least-significant bit first, and each slot samples the line so that received bits build up a byte. Reading a byte means sending 0xFF: a slave pulls a slot low to return a 0. Transmit and receive each have a buffer stage and a shift stage with their own flags. Any of the flags can raise the single interrupt line, whose polarity the host selects.

Top module: `onewire_master`

## Requirements
- R1: After reset the status register (address 2) reads 0x0C, the enable (address 3) and divisor (address 4) registers read 0, and the command register (address 0) reads 0x08 while the line is high. Command bit 3 always shows the synchronised line level.
- R2: Writing 1 to command bit 0 starts a bus reset. The line is held low for 480 ticks (70 in overdrive), then released for 480 ticks (70 in overdrive). Command bit 0 reads 1 until the cycle has ended.
- R3: 70 ticks after release (8 in overdrive), status bit 0 sets and status bit 1 records the line level: 0 means a slave answered and 1 means none did. A status read clears bit 0.
- R4: A byte written to the data register (address 1) goes out LSB first in 70-tick slots (10 in overdrive). A 1 drives low for 6 ticks and a 0 for 60 ticks.
- R5: Each slot samples the line at tick 15 (2 in overdrive). After 8 slots the received byte is readable at address 1 with status bit 4 set. A data read clears bit 4, so a read returns the AND of the sent byte and the slave's byte.
- R6: Status bit 2 is 1 when the transmit buffer is empty, and bit 3 is 0 while a byte is shifting. A byte that completes while bit 4 is set is held in the receive shift stage with bit 5 set. No new byte starts until a data read moves it to the buffer and clears bit 5.
- R7: The interrupt is active when any of status bits 0, 2, 3, 4 or 5 is set together with the matching enable bit. Enable bit 1 = 1 makes the output active-high; 0 makes it active-low.
- R8: Command bit 2 pulls the line low only while enable bit 6 is set. With the block idle and no such override, the line is never driven.
- R9: Writing 1 to command bit 5 aborts any activity, releases the line, clears the data path and the command bits, and restores status 0x0C. Enable and divisor are kept.
- R10: Command bit 7 selects the overdrive timings listed in R2 to R5.
- R11: The divisor register sets the tick to one per divisor+1 clocks, which scales every wire duration.
- R12: Command bit 1 is stored and reads back. It has no effect on the line or on the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (applies read side effects) |
| addr | input | 3 | Register address 0..4 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| dq_oe | output | 1 | Open-drain enable, 1 pulls the line low |
| dq_in | input | 1 | Line level, asynchronous |
| irq | output | 1 | Interrupt, polarity set by enable bit 1 |

## Verification
The stimulus mixes random transmit and slave bytes across divisors 0 and 1 with fixed patterns. The random pairs show whether the received byte is the AND of both sides and whether the slot pulse lengths decode back to the sent byte LSB first. The 0x3C/0xA5 and 0xFF reads separate the write path from the read path. Back-to-back bytes written without draining the receive side are the case that distinguishes a correct receive stall from data overwrite. Overdrive and divisor 3 pulse lengths expose timing-selection errors.

// File: rtl/onewire_master.sv
module onewire_master #(
  parameter int DIV_W       = 5,
  parameter int CNT_W       = 10,
  parameter int RST_LO_T    = 480,
  parameter int PD_T        = 70,
  parameter int RST_HI_T    = 480,
  parameter int SLOT_T      = 70,
  parameter int ONE_T       = 6,
  parameter int ZERO_T      = 60,
  parameter int SMP_T       = 15,
  parameter int OD_RST_LO_T = 70,
  parameter int OD_PD_T     = 8,
  parameter int OD_RST_HI_T = 70,
  parameter int OD_SLOT_T   = 10,
  parameter int OD_ONE_T    = 1,
  parameter int OD_ZERO_T   = 8,
  parameter int OD_SMP_T    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       dq_oe,
  input  logic       dq_in,
  output logic       irq
);

  typedef enum logic [1:0] {S_IDLE, S_RLO, S_RHI, S_SLOT} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       txbuf, txsh, rxsh, rxbuf;
  logic             pd, pdr, tbe, tsre, rbf, rsrf;
  logic             rst_req, srch, force_lo, od;
  logic [6:0]       en;
  logic [DIV_W-1:0] div, dcnt;
  logic [1:0]       sync;
  logic             line, tick, drive, active;

  wire wr_cmd = wr_en && addr == 3'd0;
  wire wr_dat = wr_en && addr == 3'd1;
  wire wr_en_r = wr_en && addr == 3'd3;
  wire wr_div = wr_en && addr == 3'd4;
  wire rd_dat = rd_en && addr == 3'd1;
  wire rd_st  = rd_en && addr == 3'd2;
  wire srst   = wr_cmd && wdata[5];

  wire [CNT_W-1:0] t_rlo  = od ? CNT_W'(OD_RST_LO_T) : CNT_W'(RST_LO_T);
  wire [CNT_W-1:0] t_pd   = od ? CNT_W'(OD_PD_T)     : CNT_W'(PD_T);
  wire [CNT_W-1:0] t_rhi  = od ? CNT_W'(OD_RST_HI_T) : CNT_W'(RST_HI_T);
  wire [CNT_W-1:0] t_slot = od ? CNT_W'(OD_SLOT_T)   : CNT_W'(SLOT_T);
  wire [CNT_W-1:0] t_one  = od ? CNT_W'(OD_ONE_T)    : CNT_W'(ONE_T);
  wire [CNT_W-1:0] t_zero = od ? CNT_W'(OD_ZERO_T)   : CNT_W'(ZERO_T);
  wire [CNT_W-1:0] t_smp  = od ? CNT_W'(OD_SMP_T)    : CNT_W'(SMP_T);
  wire [CNT_W-1:0] t_low  = txsh[0] ? t_one : t_zero;

  assign line  = sync[1];
  assign tick  = dcnt == div;
  assign drive = (state == S_RLO) || (state == S_SLOT && cnt < t_low);
  assign dq_oe = drive || (force_lo && en[6]);
  assign active = |({rsrf, rbf, tsre, tbe, pd} & {en[5:2], en[0]});
  assign irq   = en[1] ? active : !active;

  always_comb begin
    case (addr)
      3'd0:    rdata = {od, 3'b000, line, force_lo, srch, rst_req};
      3'd1:    rdata = rxbuf;
      3'd2:    rdata = {2'b00, rsrf, rbf, tsre, tbe, pdr, pd};
      3'd3:    rdata = {1'b0, en};
      3'd4:    rdata = {{(8-DIV_W){1'b0}}, div};
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], dq_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      div  <= '0;
      dcnt <= '0;
    end else begin
      if (wr_en_r) en <= wdata[6:0];
      if (wr_div) div <= wdata[DIV_W-1:0];
      if (wr_div || tick) dcnt <= '0;
      else                dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; bitn <= '0;
      txbuf <= '0; txsh <= '0; rxsh <= '0; rxbuf <= '0;
      pd <= 1'b0; pdr <= 1'b0; tbe <= 1'b1; tsre <= 1'b1; rbf <= 1'b0; rsrf <= 1'b0;
      rst_req <= 1'b0; srch <= 1'b0; force_lo <= 1'b0; od <= 1'b0;
    end else if (srst) begin
      state <= S_IDLE; cnt <= '0; bitn <= '0;
      txbuf <= '0; txsh <= '0; rxsh <= '0; rxbuf <= '0;
      pd <= 1'b0; pdr <= 1'b0; tbe <= 1'b1; tsre <= 1'b1; rbf <= 1'b0; rsrf <= 1'b0;
      rst_req <= 1'b0; srch <= 1'b0; force_lo <= 1'b0; od <= 1'b0;
    end else begin
      if (rd_st) pd <= 1'b0;
      if (rd_dat) rbf <= 1'b0;
      case (state)
        S_IDLE: begin
          if (rst_req) begin
            state <= S_RLO;
            cnt   <= '0;
          end else if (!tbe && !rsrf) begin
            txsh  <= txbuf;
            tbe   <= 1'b1;
            tsre  <= 1'b0;
            bitn  <= '0;
            cnt   <= '0;
            state <= S_SLOT;
          end
        end
        S_RLO: if (tick) begin
          if (cnt == t_rlo - 1'b1) begin
            state <= S_RHI;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_RHI: if (tick) begin
          if (cnt == t_pd) begin
            pd  <= 1'b1;
            pdr <= line;
          end
          if (cnt == t_rhi - 1'b1) begin
            state   <= S_IDLE;
            rst_req <= 1'b0;
            cnt     <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_SLOT: if (tick) begin
          if (cnt == t_smp) rxsh <= {line, rxsh[7:1]};
          if (cnt == t_slot - 1'b1) begin
            cnt  <= '0;
            txsh <= {1'b0, txsh[7:1]};
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) begin
              state <= S_IDLE;
              tsre  <= 1'b1;
              if (rbf && !rd_dat) rsrf <= 1'b1;
              else begin
                rxbuf <= rxsh;
                rbf   <= 1'b1;
              end
            end
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
      if (rsrf && rd_dat) begin
        rxbuf <= rxsh;
        rbf   <= 1'b1;
        rsrf  <= 1'b0;
      end
      if (wr_cmd) begin
        if (wdata[0]) rst_req <= 1'b1;
        srch     <= wdata[1];
        force_lo <= wdata[2];
        od       <= wdata[7];
      end
      if (wr_dat) begin
        txbuf <= wdata;
        tbe   <= 1'b0;
      end
    end
  end

  assert_reset_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RLO || state == S_RHI) |-> rst_req);

  assert_rsrf_needs_rbf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsrf |-> rbf);

  assert_rx_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsrf |-> state != S_SLOT);

  assert_tsre_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_SLOT |-> !tsre);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !(force_lo && en[6])) |-> !dq_oe);

  assert_pd_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && en[0]) |-> irq == en[1]);

  assert_tick_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && !wr_div) |=> !tick);

endmodule

// File: tb/onewire_master_tb.sv
`timescale 1ns/1ps
module onewire_master_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       dq_oe, irq, dq_in;

  int npass = 0, ntot = 0, cyc = 0;
  int bdiv = 0;
  bit sl_present = 1'b0;
  logic [7:0] sl_byte = 8'hFF;

  int plen [0:255];
  int mon_n = 0, run = 0, hold = 0, sl_idx = 0;
  logic slave_low = 1'b0, prev_oe = 1'b0;

  always #2.5 clk = ~clk;

  onewire_master u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dq_oe(dq_oe), .dq_in(dq_in), .irq(irq)
  );

  assign dq_in = !(dq_oe || slave_low);

  always @(negedge clk) begin
    if (hold > 0) begin
      hold = hold - 1;
      if (hold == 0) slave_low = 1'b0;
    end
    if (dq_oe && !prev_oe && hold == 0) begin
      slave_low = !sl_byte[sl_idx];
      hold = 35 * (bdiv + 1);
      sl_idx = (sl_idx + 1) % 8;
    end
    if (!dq_oe && prev_oe) begin
      plen[mon_n % 256] = run;
      mon_n = mon_n + 1;
      if (run >= 200 * (bdiv + 1)) begin
        sl_idx = 0;
        slave_low = sl_present;
        hold = sl_present ? 150 * (bdiv + 1) : 0;
      end
    end
    run = dq_oe ? run + 1 : 0;
    prev_oe = dq_oe;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 190000) begin
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      $display("%0d/%0d checks passed", npass, ntot + 1);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    ntot++;
    if (ok) npass++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic bus_reset(input logic [7:0] cmd);
    logic [7:0] v;
    wr(3'd0, cmd);
    do rd(3'd0, v); while (v[0]);
  endtask

  task automatic wait_done(output logic [7:0] s);
    do rd(3'd2, s); while (!(s[2] && s[3]));
  endtask

  function automatic logic [7:0] decode(input int n0);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = plen[(n0 + i) % 256] < 30 * (bdiv + 1);
    return b;
  endfunction

  function automatic bit in_win(input int v, input int ticks);
    return v >= ticks * (bdiv + 1) - bdiv && v <= ticks * (bdiv + 1) + bdiv + 2;
  endfunction

  initial begin
    logic [7:0] v, s, rx, tx;
    int n0;
    void'($urandom(1234));
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    rd(3'd2, v); check(v == 8'h0C, "R1 status", v, 8'h0C);
    rd(3'd0, v); check(v == 8'h08, "R1 command", v, 8'h08);
    rd(3'd3, v); check(v == 8'h00, "R1 enable", v, 0);
    rd(3'd4, v); check(v == 8'h00, "R1 divisor", v, 0);
    check(irq == 1'b1, "R7 idle active-low", irq, 1);

    sl_present = 1'b1;
    n0 = mon_n;
    wr(3'd0, 8'h01);
    rd(3'd0, v); check(v[0] == 1'b1, "R2 busy", v[0], 1);
    do rd(3'd0, v); while (v[0]);
    check(in_win(plen[n0 % 256], 480), "R2 low length", plen[n0 % 256], 480);
    rd(3'd2, v); check(v[1:0] == 2'b01, "R3 present", v[1:0], 1);
    rd(3'd2, v); check(v[0] == 1'b0, "R3 clear on read", v[0], 0);

    sl_present = 1'b0;
    bus_reset(8'h01);
    rd(3'd2, v); check(v[1:0] == 2'b11, "R3 absent", v[1:0], 3);

    sl_present = 1'b1;
    wr(3'd3, 8'h03);
    bus_reset(8'h01);
    check(irq == 1'b1, "R7 pd active-high", irq, 1);
    rd(3'd2, v);
    check(irq == 1'b0, "R7 pd cleared", irq, 0);
    wr(3'd3, 8'h10);
    sl_byte = 8'h96;
    wr(3'd1, 8'hFF); wait_done(s);
    check(irq == 1'b0, "R7 rbf active-low", irq, 0);
    rd(3'd1, v); check(v == 8'h96, "R5 read 0xFF", v, 8'h96);
    check(irq == 1'b1, "R7 rbf cleared", irq, 1);

    sl_byte = 8'hA5;
    n0 = mon_n;
    wr(3'd1, 8'h3C); wait_done(s);
    check(s[4] == 1'b1, "R5 rbf set", s, 8'h1C);
    check(decode(n0) == 8'h3C, "R4 lsb first", decode(n0), 8'h3C);
    check(in_win(plen[n0 % 256], 60), "R4 zero pulse", plen[n0 % 256], 60);
    check(in_win(plen[(n0 + 2) % 256], 6), "R4 one pulse", plen[(n0 + 2) % 256], 6);
    rd(3'd1, v); check(v == (8'h3C & 8'hA5), "R5 and", v, 8'h3C & 8'hA5);
    rd(3'd2, v); check(v[4] == 1'b0, "R5 rbf cleared", v[4], 0);

    sl_byte = 8'h5A;
    wr(3'd1, 8'h81);
    do rd(3'd2, s); while (!s[2]);
    wr(3'd1, 8'h7E);
    rd(3'd2, v); check(v[3:2] == 2'b00, "R6 both busy", v[3:2], 0);
    wait_done(s);
    check(s[5:4] == 2'b11, "R6 rsrf hold", s[5:4], 3);
    wr(3'd1, 8'hC3);
    n0 = mon_n;
    repeat (300) @(negedge clk);
    check(mon_n == n0, "R6 stall", mon_n, n0);
    rd(3'd1, v); check(v == (8'h81 & 8'h5A), "R6 first byte", v, 8'h81 & 8'h5A);
    rd(3'd2, v); check(v[5:4] == 2'b01, "R6 drained", v[5:4], 1);
    rd(3'd1, v); check(v == (8'h7E & 8'h5A), "R6 second byte", v, 8'h7E & 8'h5A);
    wait_done(s);
    rd(3'd1, v); check(v == (8'hC3 & 8'h5A), "R6 third byte", v, 8'hC3 & 8'h5A);

    wr(3'd3, 8'h00);
    wr(3'd0, 8'h04);
    repeat (5) @(negedge clk);
    check(dq_oe == 1'b0, "R8 gated", dq_oe, 0);
    wr(3'd3, 8'h40);
    check(dq_oe == 1'b1, "R8 forced", dq_oe, 1);
    repeat (5) @(negedge clk);
    rd(3'd0, v); check((v & 8'h0C) == 8'h04, "R8 line low", v, 8'h04);
    wr(3'd0, 8'h00);
    repeat (100) @(negedge clk);
    rd(3'd0, v); check(v == 8'h08, "R8 line back", v, 8'h08);

    wr(3'd0, 8'h02);
    rd(3'd0, v); check(v == 8'h0A, "R12 readback", v, 8'h0A);
    n0 = mon_n;
    repeat (100) @(negedge clk);
    check(mon_n == n0, "R12 no bus", mon_n, n0);
    rd(3'd2, v); check(v == 8'h0C, "R12 status", v, 8'h0C);
    wr(3'd0, 8'h00);

    bdiv = 3;
    wr(3'd4, 8'h03);
    rd(3'd4, v); check(v == 8'h03, "R11 readback", v, 3);
    bus_reset(8'h01);
    sl_byte = 8'hFF;
    n0 = mon_n;
    wr(3'd1, 8'h01); wait_done(s);
    check(in_win(plen[n0 % 256], 6), "R11 one scaled", plen[n0 % 256], 24);
    check(in_win(plen[(n0 + 1) % 256], 60), "R11 zero scaled", plen[(n0 + 1) % 256], 240);
    rd(3'd1, v); check(v == 8'h01, "R11 data", v, 1);

    bdiv = 0;
    wr(3'd4, 8'h00);
    sl_present = 1'b0;
    n0 = mon_n;
    bus_reset(8'h81);
    check(in_win(plen[n0 % 256], 70), "R10 od low", plen[n0 % 256], 70);
    rd(3'd2, v); check(v[1:0] == 2'b11, "R10 od pd", v[1:0], 3);
    rd(3'd0, v); check(v == 8'h88, "R10 od bit", v, 8'h88);
    wr(3'd0, 8'h00);

    sl_present = 1'b1;
    for (int i = 0; i < 16; i++) begin
      bdiv = int'($urandom % 2);
      wr(3'd4, 8'(bdiv));
      bus_reset(8'h01);
      tx = 8'($urandom);
      sl_byte = 8'($urandom);
      n0 = mon_n;
      wr(3'd1, tx); wait_done(s);
      check(decode(n0) == tx, "R4 random bits", decode(n0), tx);
      rd(3'd1, rx); check(rx == (tx & sl_byte), "R5 random rx", rx, tx & sl_byte);
    end

    bdiv = 0;
    wr(3'd4, 8'h00);
    wr(3'd3, 8'h15);
    wr(3'd1, 8'h00);
    repeat (30) @(negedge clk);
    check(dq_oe == 1'b1, "R9 mid slot", dq_oe, 1);
    wr(3'd0, 8'h20);
    check(dq_oe == 1'b0, "R9 released", dq_oe, 0);
    rd(3'd2, v); check(v == 8'h0C, "R9 status", v, 8'h0C);
    n0 = mon_n;
    repeat (60) @(negedge clk);
    rd(3'd0, v); check(v == 8'h08, "R9 command", v, 8'h08);
    rd(3'd3, v); check(v == 8'h15, "R9 enable kept", v, 8'h15);
    check(mon_n == n0, "R9 no resume", mon_n, n0);

    $display("%0d/%0d checks passed", npass, ntot);
    $finish;
  end
endmodule